// File: doc/BRIEF.md
# Holdover Frequency Register with Running Average

This block keeps the frequency word a digital PLL falls back on when its reference is lost. It stores a value written by the host. It also keeps a first-order running average of the loop's frequency samples. The `holdFreq` output carries whichever of the two the mode settings select, and the loop uses that word while it is frozen.

A small register port gives the host access to two locations. One is the frequency word. The other is a mode word. One mode bit redirects reads of the frequency location to the filter output. With that bit set, software can collect the smoothed frequency and post-process it, for example against temperature, and then write a corrected value back. This read path works in every holdover mode. The host can rewrite the frequency word while the loop is in holdover, and the new word reaches the output on the next cycle.

Top module: `holdover_freq_reg`

## Requirements
- R1: After reset the stored word, the average and the mode word are zero. `regRdata` and `holdFreq` read 0.
- R2: A write with `regWe` high and `regAddr` = 0 stores `regWdata`. With mode bit 3 clear, placing address 0 on `regAddr` returns the stored word on `regRdata` one cycle later.
- R3: With mode bit 3 (read-average) set, address 0 returns the running average instead of the stored word. This holds whatever mode bits 0–2 hold.
- R4: With mode bit 0 (manual) set, `holdFreq` equals the stored word, even when mode bit 1 is also set.
- R5: With mode bit 0 clear and mode bit 1 (auto-average) set, `holdFreq` equals the running average. With both bits clear it equals the stored word.
- R6: On each cycle with `sampleValid` high and `inHoldover` low, the average updates as avg + ((sample − avg) >>> k). The arithmetic is signed two's complement with a floor shift. k = FAST_K (2) when mode bits 1 and 2 are both set, and SLOW_K (5) otherwise.
- R7: The average holds its value in any cycle where `sampleValid` is low or `inHoldover` is high.
- R8: A write to address 0 while `inHoldover` is high appears on `holdFreq` in the next cycle when the stored word is selected.
- R9: Address 1 is the mode word. A write keeps `regWdata[3:0]`, and reads return those 4 bits with the upper bits zero. Addresses 2 and 3 read 0, and writes to them change neither the stored word nor the mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Frequency sample strobe |
| sampleFreq | input | 16 | Signed loop frequency sample |
| inHoldover | input | 1 | Loop is frozen in holdover |
| regWe | input | 1 | Single-cycle register write enable |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Registered read data, one cycle after address |
| holdFreq | output | 16 | Signed holdover frequency word |

## Verification
The filter is fed a table of samples in both fast and slow mode. The table holds repeated values, large positive and negative swings at the extremes of the signed range, and cycles with no strobe or with holdover asserted. Reading the average back through the register port on each cycle separates a correct shift constant from a wrong one, an arithmetic shift from a logical one, and a filter that freezes from one that does not. Directed cycles then sweep the mode bits across manual, automatic and neither. These cycles show that output selection and read redirection are independent, and that writes made during holdover, writes to unused addresses and a second reset behave as required.

// File: rtl/hofreq_pkg.sv
package hofreq_pkg;

  localparam int CFG_BITS   = 4;
  localparam int CFG_MANUAL = 0;
  localparam int CFG_AUTO   = 1;
  localparam int CFG_FAST   = 2;
  localparam int CFG_RDAVG  = 3;

  localparam int ADDR_FREQ  = 0;
  localparam int ADDR_CFG   = 1;

  typedef enum logic {
    HOLD_STORED = 1'b0,
    HOLD_AVG    = 1'b1
  } holdSrc_e;

  typedef enum logic [1:0] {
    RD_STORED = 2'd0,
    RD_AVG    = 2'd1,
    RD_CFG    = 2'd2,
    RD_NONE   = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic     loadFreq;
    logic     stepAvg;
    logic     useFast;
    holdSrc_e holdSrc;
    rdSrc_e   rdSrc;
  } hofreq_ctl_t;

endpackage

// File: rtl/hofreq_ctrl.sv
module hofreq_ctrl
  import hofreq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CFG_BITS-1:0] cfgWdata,
  input  logic                sampleValid,
  input  logic                inHoldover,
  output hofreq_ctl_t         ctl,
  output logic [CFG_BITS-1:0] cfgQ
);

  logic addrFreq;
  logic addrCfg;

  assign addrFreq = (regAddr == ADDR_W'(ADDR_FREQ));
  assign addrCfg  = (regAddr == ADDR_W'(ADDR_CFG));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (regWe && addrCfg) begin
      cfgQ <= cfgWdata;
    end
  end

  always_comb begin
    ctl.loadFreq = regWe && addrFreq;
    ctl.stepAvg  = sampleValid && !inHoldover;
    ctl.useFast  = cfgQ[CFG_AUTO] && cfgQ[CFG_FAST];
    ctl.holdSrc  = (!cfgQ[CFG_MANUAL] && cfgQ[CFG_AUTO]) ? HOLD_AVG : HOLD_STORED;
    if (addrFreq) begin
      ctl.rdSrc = cfgQ[CFG_RDAVG] ? RD_AVG : RD_STORED;
    end else if (addrCfg) begin
      ctl.rdSrc = RD_CFG;
    end else begin
      ctl.rdSrc = RD_NONE;
    end
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && addrCfg) |=> (cfgQ == $past(cfgWdata))); // R9

endmodule

// File: rtl/hofreq_dpath.sv
module hofreq_dpath
  import hofreq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FAST_K = 2,
  parameter int SLOW_K = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  hofreq_ctl_t         ctl,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   sampleFreq,
  input  logic [CFG_BITS-1:0] cfgWord,
  output logic [DATA_W-1:0]   storedQ,
  output logic [DATA_W-1:0]   avgQ,
  output logic [DATA_W-1:0]   holdFreq,
  output logic [DATA_W-1:0]   rdData
);

  localparam int EXT_W = DATA_W + 1;

  logic signed [EXT_W-1:0]  diff;
  logic signed [EXT_W-1:0]  stepFast;
  logic signed [EXT_W-1:0]  stepSlow;
  logic signed [EXT_W-1:0]  stepSel;
  logic        [DATA_W-1:0] avgNext;
  logic        [DATA_W-1:0] rdNext;

  // Sign-extended difference, then floor shift by the selected constant
  assign diff     = $signed({sampleFreq[DATA_W-1], sampleFreq}) - $signed({avgQ[DATA_W-1], avgQ});
  assign stepFast = diff >>> FAST_K;
  assign stepSlow = diff >>> SLOW_K;
  assign stepSel  = ctl.useFast ? stepFast : stepSlow;
  assign avgNext  = avgQ + stepSel[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedQ <= '0;
      avgQ    <= '0;
    end else begin
      if (ctl.loadFreq) storedQ <= wdata;
      if (ctl.stepAvg)  avgQ    <= avgNext;
    end
  end

  assign holdFreq = (ctl.holdSrc == HOLD_AVG) ? avgQ : storedQ;

  always_comb begin
    rdNext = '0;
    unique case (ctl.rdSrc)
      RD_STORED: rdNext = storedQ;
      RD_AVG:    rdNext = avgQ;
      RD_CFG:    rdNext[CFG_BITS-1:0] = cfgWord;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stepAvg |=> $stable(avgQ)); // R7

endmodule

// File: rtl/holdover_freq_reg.sv
module holdover_freq_reg
  import hofreq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int FAST_K = 2,
  parameter int SLOW_K = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleFreq,
  input  logic              inHoldover,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] holdFreq
);

  hofreq_ctl_t         ctl;
  logic [CFG_BITS-1:0] cfgQ;
  logic [DATA_W-1:0]   storedQ;
  logic [DATA_W-1:0]   avgQ;

  hofreq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .cfgWdata    (regWdata[CFG_BITS-1:0]),
    .sampleValid (sampleValid),
    .inHoldover  (inHoldover),
    .ctl         (ctl),
    .cfgQ        (cfgQ)
  );

  hofreq_dpath #(.DATA_W(DATA_W), .FAST_K(FAST_K), .SLOW_K(SLOW_K)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wdata      (regWdata),
    .sampleFreq (sampleFreq),
    .cfgWord    (cfgQ),
    .storedQ    (storedQ),
    .avgQ       (avgQ),
    .holdFreq   (holdFreq),
    .rdData     (regRdata)
  );

  logic signed [DATA_W-1:0] avgS;
  logic signed [DATA_W-1:0] sampleS;
  assign avgS    = avgQ;
  assign sampleS = sampleFreq;

  AST_AVG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid || inHoldover) |=> $stable(avgQ)); // R7

  AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !inHoldover) |=>
      (((avgS >= $past(avgS)) && (avgS <= $past(sampleS))) ||
       ((avgS <= $past(avgS)) && (avgS >= $past(sampleS))))); // R6

  AST_MANUAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(ADDR_FREQ) && cfgQ[CFG_MANUAL]) |=>
      (holdFreq == $past(regWdata))); // R4

  AST_READ_AVG: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_FREQ) && cfgQ[CFG_RDAVG]) |=> (regRdata == $past(avgQ))); // R3

  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr > ADDR_W'(ADDR_CFG)) |=> ($stable(storedQ) && $stable(cfgQ))); // R9

endmodule

// File: tb/holdover_freq_reg_test.sv
module holdover_freq_reg_test;

  localparam int CLK_P = 10;
  localparam int NVEC  = 10;
  // {sampleValid, inHoldover, sample}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'h1000}, {1'b1, 1'b0, 16'h1000}, {1'b0, 1'b0, 16'h7FFF},
    {1'b1, 1'b0, 16'hF000}, {1'b1, 1'b1, 16'h4000}, {1'b1, 1'b0, 16'h7FFF},
    {1'b1, 1'b0, 16'h8000}, {1'b1, 1'b0, 16'h0001}, {1'b1, 1'b0, 16'hFFFF},
    {1'b0, 1'b1, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleValid;
  logic [15:0] sampleFreq;
  logic        inHoldover;
  logic        regWe;
  logic [1:0]  regAddr;
  logic [15:0] regWdata;
  logic [15:0] regRdata;
  logic [15:0] holdFreq;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] mStored;
  logic [15:0] mAvg;
  logic [3:0]  mCfg;

  holdover_freq_reg uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleFreq(sampleFreq),
    .inHoldover(inHoldover), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .holdFreq(holdFreq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] filt(input logic [15:0] a, input logic [15:0] s, input int k);
    logic signed [16:0] d;
    d = $signed({s[15], s}) - $signed({a[15], a});
    d = d >>> k;
    return a + d[15:0];
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic runCycle(input logic we, input logic [1:0] addr, input logic [15:0] wd,
                          input logic sv, input logic [15:0] smp, input logic hd,
                          input string tag);
    logic [15:0] expRd;
    logic [15:0] expH;
    int k;
    if (addr == 2'd0)      expRd = mCfg[3] ? mAvg : mStored;
    else if (addr == 2'd1) expRd = {12'd0, mCfg};
    else                   expRd = 16'd0;
    k = (mCfg[1] && mCfg[2]) ? 2 : 5;
    if (sv && !hd) mAvg = filt(mAvg, smp, k);
    if (we && addr == 2'd0) mStored = wd;
    if (we && addr == 2'd1) mCfg = wd[3:0];
    expH = mCfg[0] ? mStored : (mCfg[1] ? mAvg : mStored);
    regWe = we; regAddr = addr; regWdata = wd;
    sampleValid = sv; sampleFreq = smp; inHoldover = hd;
    @(posedge clk); #1;
    regWe = 1'b0; sampleValid = 1'b0;
    check({tag, " rdata"}, regRdata, expRd);
    check({tag, " hold"}, holdFreq, expH);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    regWe = 1'b0; regAddr = 2'd0; regWdata = 16'd0;
    sampleValid = 1'b0; sampleFreq = 16'd0; inHoldover = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    mStored = 16'd0; mAvg = 16'd0; mCfg = 4'd0;
  endtask

  initial begin
    #(CLK_P * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state
    check("R1 reset rdata", regRdata, 16'd0);
    check("R1 reset hold", holdFreq, 16'd0);
    runCycle(1'b0, 2'd0, 16'd0, 1'b0, 16'd0, 1'b0, "R1 read freq");
    runCycle(1'b0, 2'd1, 16'd0, 1'b0, 16'd0, 1'b0, "R1 read cfg");

    // Fast auto averaging with read-average: walk the sample table (R3 R5 R6 R7)
    runCycle(1'b1, 2'd1, 16'h000E, 1'b0, 16'd0, 1'b0, "R9 cfg fast");
    for (int i = 0; i < NVEC; i++) begin
      runCycle(1'b0, 2'd0, 16'd0, VEC[i][17], VEC[i][15:0], VEC[i][16], "R6 R7 fast vec");
    end
    // Slow averaging: same table again
    runCycle(1'b1, 2'd1, 16'h000A, 1'b0, 16'd0, 1'b0, "R9 cfg slow");
    for (int i = 0; i < NVEC; i++) begin
      runCycle(1'b0, 2'd0, 16'd0, VEC[i][17], VEC[i][15:0], VEC[i][16], "R6 R7 slow vec");
    end

    // R4: manual overrides auto
    runCycle(1'b1, 2'd1, 16'h0003, 1'b0, 16'd0, 1'b0, "R4 cfg manual+auto");
    runCycle(1'b1, 2'd0, 16'h1234, 1'b1, 16'h2000, 1'b0, "R4 write stored");
    runCycle(1'b0, 2'd0, 16'd0, 1'b0, 16'd0, 1'b0, "R2 read stored");
    // R3: read-average while manual selected
    runCycle(1'b1, 2'd1, 16'h0009, 1'b0, 16'd0, 1'b0, "R3 cfg manual+rdavg");
    runCycle(1'b0, 2'd0, 16'd0, 1'b1, 16'h7000, 1'b0, "R3 read avg manual");
    runCycle(1'b0, 2'd0, 16'd0, 1'b0, 16'd0, 1'b0, "R3 read avg again");

    // R8: writes during holdover take effect
    runCycle(1'b1, 2'd0, 16'hABCD, 1'b1, 16'h0100, 1'b1, "R8 R7 holdover write");
    runCycle(1'b1, 2'd0, 16'h8001, 1'b1, 16'h0200, 1'b1, "R8 holdover rewrite");
    runCycle(1'b0, 2'd0, 16'd0, 1'b0, 16'd0, 1'b1, "R8 R7 holdover idle");

    // R5: neither manual nor auto selects stored; auto alone selects average
    runCycle(1'b1, 2'd1, 16'h0000, 1'b0, 16'd0, 1'b0, "R5 cfg none");
    runCycle(1'b0, 2'd0, 16'd0, 1'b1, 16'h5555, 1'b0, "R5 R2 none stored");
    runCycle(1'b1, 2'd1, 16'h0002, 1'b0, 16'd0, 1'b0, "R5 cfg auto");
    runCycle(1'b0, 2'd0, 16'd0, 1'b1, 16'h5555, 1'b0, "R5 R6 auto avg");

    // R9: cfg width, unused addresses
    runCycle(1'b1, 2'd1, 16'hFFF7, 1'b0, 16'd0, 1'b0, "R9 cfg wide write");
    runCycle(1'b0, 2'd1, 16'd0, 1'b0, 16'd0, 1'b0, "R9 cfg readback");
    runCycle(1'b1, 2'd2, 16'h0000, 1'b0, 16'd0, 1'b0, "R9 write addr2");
    runCycle(1'b1, 2'd3, 16'h0000, 1'b0, 16'd0, 1'b0, "R9 write addr3");
    runCycle(1'b0, 2'd2, 16'd0, 1'b0, 16'd0, 1'b0, "R9 read addr2");
    runCycle(1'b0, 2'd1, 16'd0, 1'b0, 16'd0, 1'b0, "R9 cfg unchanged");
    runCycle(1'b1, 2'd1, 16'h0000, 1'b0, 16'd0, 1'b0, "R9 cfg clear");
    runCycle(1'b0, 2'd0, 16'd0, 1'b0, 16'd0, 1'b0, "R9 stored unchanged");

    // R1: second reset clears non-zero state
    doReset();
    check("R1 rereset rdata", regRdata, 16'd0);
    check("R1 rereset hold", holdFreq, 16'd0);
    runCycle(1'b1, 2'd1, 16'h0008, 1'b0, 16'd0, 1'b0, "R1 cfg rdavg");
    runCycle(1'b0, 2'd0, 16'd0, 1'b0, 16'd0, 1'b0, "R1 avg cleared");

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule